// File: doc/BRIEF.md
# Divided-Tick Counter with Two Match Alarms

This peripheral keeps a 32-bit count of slow ticks taken from a low-rate reference clock (nominally 32768 Hz). A programmable prescaler turns the reference into a tick whose period is twice the programmed value plus one. Each tick advances the counter. Software may load the counter at any time, and counting resumes from the loaded value.

Two alarm words are compared with the counter. When the counter steps onto an alarm value while that alarm is armed, a sticky pending flag is raised. A third sticky flag marks every tick. Each flag has an enable bit. The enabled flags are ORed into a single interrupt line.

A run-select field starts and stops counting. A spare 32-bit retained word is available for software bookkeeping, such as the upper bits of a longer time base. All registers sit behind a plain synchronous register port with a registered read path.

Top module: `rtc_dual_alarm`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0. Read data appears on `bus_rdata` one clock after the address is presented. Any offset not listed in R2 reads 0.
- R2: Register offsets and widths: count 0x00 (32 bits), alarm A 0x04 (32), status 0x08, prescale 0x0C (DIV_W bits, zero-extended on read), alarm B 0x18 (32), run select 0x1C (2 bits), spare word 0x40 (32). Alarms, spare, prescale and run select read back what was written.
- R3: While running, ticks come every 2×(D+1) clocks, where D is the prescale value. A write to prescale or count restarts the phase, so the first tick after counting starts arrives 2×(D+1) clocks later.
- R4: Each tick adds one to the count, and the count wraps from 0xFFFFFFFF to 0.
- R5: A write to count loads the value, and later ticks continue from it.
- R6: Counting and the prescaler advance only while run select equals 3. With the values 0, 1 or 2 the count is frozen.
- R7: Status bit layout: bit 0 alarm A pending, bit 1 tick pending, bit 2 alarm A enable, bit 3 tick enable, bit 4 alarm B pending, bit 6 alarm B enable. All other bits read 0.
- R8: Tick pending is set on every tick, whatever its enable.
- R9: Alarm A pending is set only when a tick moves the count onto the alarm A value while alarm A enable is 1. It is not set while the enable is 0, and it is not set by a software load of an equal value.
- R10: Alarm B pending behaves like alarm A pending, using the alarm B word and enable. This includes a match reached through the wrap to 0.
- R11: In a status write, a 1 in a pending position clears that flag, and a 0 leaves it unchanged. The enable bits take the written values.
- R12: If a flag is set and cleared in the same cycle, the set wins.
- R13: `irq` is high exactly when some pending flag and its own enable are both 1. It follows the status register without extra delay.
- R14: The spare word holds its value and has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Registered read data |
| irq | output | 1 | Combined interrupt |

## Verification
Tick or alarm events that raise a pending flag can land on the same clock edge as a software write of 1 that clears that flag. The bench starts the counter with the smallest prescale value, so ticks fall on known even edges. It then times a status write to hit exactly the edge where the counter steps onto the alarm value, and in a second run the edge of a plain tick. After the counter is stopped, status is read back. The flag must still be set while the other bits match the written enables; a cleared flag means the clear won the race.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    // Register byte offsets (decoded by neighbours' software)
    localparam int OFS_COUNT  = 'h00;
    localparam int OFS_ALM_A  = 'h04;
    localparam int OFS_STATUS = 'h08;
    localparam int OFS_PRESC  = 'h0C;
    localparam int OFS_ALM_B  = 'h18;
    localparam int OFS_RUNSEL = 'h1C;
    localparam int OFS_SPARE  = 'h40;

    // Status bit positions
    localparam int SB_A_PEND = 0;
    localparam int SB_T_PEND = 1;
    localparam int SB_A_EN   = 2;
    localparam int SB_T_EN   = 3;
    localparam int SB_B_PEND = 4;
    localparam int SB_B_EN   = 6;

    localparam logic [1:0] RUNSEL_GO = 2'b11;

    localparam int NUM_ALARMS = 2;

    // One bit per event source
    typedef struct packed {
        logic alm_b;
        logic tick;
        logic alm_a;
    } evt_t;

    function automatic int alarm_offset(input int idx);
        return (idx == 0) ? OFS_ALM_A : OFS_ALM_B;
    endfunction

    function automatic logic [6:0] status_bits(input evt_t pend, input evt_t en);
        logic [6:0] s;
        s = '0;
        s[SB_A_PEND] = pend.alm_a;
        s[SB_T_PEND] = pend.tick;
        s[SB_A_EN]   = en.alm_a;
        s[SB_T_EN]   = en.tick;
        s[SB_B_PEND] = pend.alm_b;
        s[SB_B_EN]   = en.alm_b;
        return s;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PH_W = DIV_W + 1;

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] last_phase;

    // Period is 2*(div+1): phase runs 0 .. 2*div+1
    assign last_phase = {div, 1'b1};
    assign tick       = run && (phase == last_phase);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= '0;
        end else if (run) begin
            phase <= tick ? '0 : phase + PH_W'(1);
        end
    end

    // R3: phase never runs past the terminal value
    assert_phase_bounded_R3: assert property (@(posedge clk) disable iff (rst)
        phase <= last_phase);

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] value,
    output logic [CNT_W-1:0] value_next
);
    assign value_next = value + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (inc) begin
            value <= value_next;
        end
    end

    // R4: a step adds exactly one, wrapping at the top
    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        (inc && !load) |=> (value == $past(value) + CNT_W'(1)));

    // R5: a load takes the written value
    assert_load_value_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> (value == $past(load_val)));

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             step,
    input  logic [CNT_W-1:0] next_val,
    output logic [CNT_W-1:0] value,
    output logic             hit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (wr) begin
            value <= wdata;
        end
    end

    // Match only when the count steps onto the alarm value
    assign hit = step && (next_val == value);

endmodule

// File: rtl/rtc_dual_alarm.sv
module rtc_dual_alarm
    import rtc_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DIV_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    // Address decode
    logic wr_count, wr_status, wr_presc, wr_runsel, wr_spare;
    assign wr_count  = bus_wr && (bus_addr == ADDR_W'(OFS_COUNT));
    assign wr_status = bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));
    assign wr_presc  = bus_wr && (bus_addr == ADDR_W'(OFS_PRESC));
    assign wr_runsel = bus_wr && (bus_addr == ADDR_W'(OFS_RUNSEL));
    assign wr_spare  = bus_wr && (bus_addr == ADDR_W'(OFS_SPARE));

    logic [DIV_W-1:0] presc_q;
    logic [1:0]       runsel_q;
    logic [CNT_W-1:0] spare_q;
    evt_t             pend_q, en_q;

    logic run, tick, step;
    logic [CNT_W-1:0] count, count_next;

    assign run = (runsel_q == RUNSEL_GO);

    rtc_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (wr_presc || wr_count),
        .div     (presc_q),
        .tick    (tick)
    );

    // A software load takes priority over a tick
    assign step = tick && !wr_count;

    rtc_counter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .load       (wr_count),
        .load_val   (bus_wdata),
        .inc        (step),
        .value      (count),
        .value_next (count_next)
    );

    logic [CNT_W-1:0] alm_val [NUM_ALARMS];
    logic [NUM_ALARMS-1:0] alm_hit;

    for (genvar gi = 0; gi < NUM_ALARMS; gi++) begin : g_alarm
        rtc_alarm #(.CNT_W(CNT_W)) u_alarm (
            .clk      (clk),
            .rst      (rst),
            .wr       (bus_wr && (bus_addr == ADDR_W'(alarm_offset(gi)))),
            .wdata    (bus_wdata),
            .step     (step),
            .next_val (count_next),
            .value    (alm_val[gi]),
            .hit      (alm_hit[gi])
        );
    end

    // Event set and clear vectors
    evt_t ev_set, ev_clr;
    always_comb begin
        ev_set.alm_a = alm_hit[0] && en_q.alm_a;
        ev_set.alm_b = alm_hit[1] && en_q.alm_b;
        ev_set.tick  = step;
        ev_clr       = '0;
        if (wr_status) begin
            ev_clr.alm_a = bus_wdata[SB_A_PEND];
            ev_clr.tick  = bus_wdata[SB_T_PEND];
            ev_clr.alm_b = bus_wdata[SB_B_PEND];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            presc_q  <= '0;
            runsel_q <= '0;
            spare_q  <= '0;
            pend_q   <= '0;
            en_q     <= '0;
        end else begin
            if (wr_presc)  presc_q  <= bus_wdata[DIV_W-1:0];
            if (wr_runsel) runsel_q <= bus_wdata[1:0];
            if (wr_spare)  spare_q  <= bus_wdata;
            if (wr_status) begin
                en_q.alm_a <= bus_wdata[SB_A_EN];
                en_q.tick  <= bus_wdata[SB_T_EN];
                en_q.alm_b <= bus_wdata[SB_B_EN];
            end
            // set wins over a concurrent clear
            pend_q <= (pend_q & ~ev_clr) | ev_set;
        end
    end

    assign irq = |(pend_q & en_q);

    // Registered read path
    logic [CNT_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if      (bus_addr == ADDR_W'(OFS_COUNT))  rd_mux = count;
        else if (bus_addr == ADDR_W'(OFS_ALM_A))  rd_mux = alm_val[0];
        else if (bus_addr == ADDR_W'(OFS_STATUS)) rd_mux = CNT_W'(status_bits(pend_q, en_q));
        else if (bus_addr == ADDR_W'(OFS_PRESC))  rd_mux = CNT_W'(presc_q);
        else if (bus_addr == ADDR_W'(OFS_ALM_B))  rd_mux = alm_val[1];
        else if (bus_addr == ADDR_W'(OFS_RUNSEL)) rd_mux = CNT_W'(runsel_q);
        else if (bus_addr == ADDR_W'(OFS_SPARE))  rd_mux = spare_q;
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_mux;
    end

    // R6: count frozen unless run select is 3 (or software loads it)
    assert_frozen_when_stopped_R6: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_count) |=> $stable(count));

    // R8: every tick leaves tick pending set
    assert_tick_sets_pending_R8: assert property (@(posedge clk) disable iff (rst)
        step |=> pend_q.tick);

    // R9: alarm A pending cannot appear while disarmed
    assert_alarm_a_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
        (!en_q.alm_a && !pend_q.alm_a) |=> !pend_q.alm_a);

    // R10: alarm B pending cannot appear while disarmed
    assert_alarm_b_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
        (!en_q.alm_b && !pend_q.alm_b) |=> !pend_q.alm_b);

    // R11: write-one clears tick pending when no tick competes
    assert_w1c_clears_R11: assert property (@(posedge clk) disable iff (rst)
        (wr_status && bus_wdata[SB_T_PEND] && !step) |=> !pend_q.tick);

endmodule

// File: tb/rtc_dual_alarm_tb.sv
module rtc_dual_alarm_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rtc_dual_alarm u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks are entered at a falling edge and leave at one
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values and unmapped offsets
        chk("R1 irq", {31'd0, irq}, 0);
        foreach (v[i]) begin end
        rd_chk("R1 count",  8'h00, 0);
        rd_chk("R1 almA",   8'h04, 0);
        rd_chk("R1 status", 8'h08, 0);
        rd_chk("R1 presc",  8'h0C, 0);
        rd_chk("R1 almB",   8'h18, 0);
        rd_chk("R1 runsel", 8'h1C, 0);
        rd_chk("R1 spare",  8'h40, 0);
        rd_chk("R1 unmapped", 8'h10, 0);
        rd_chk("R1 unmapped", 8'h44, 0);

        // R2 / R5 / R14: read-back sweep while stopped
        for (int i = 0; i < 8; i++) begin
            logic [31:0] p;
            p = 32'h9E37_79B9 * (i + 1) ^ (32'h1 << (i * 4));
            wr(8'h04, p);          rd_chk("R2 almA", 8'h04, p);
            wr(8'h18, ~p);         rd_chk("R2 almB", 8'h18, ~p);
            wr(8'h0C, p);          rd_chk("R2 presc", 8'h0C, {16'd0, p[15:0]});
            wr(8'h1C, p);          rd_chk("R2 runsel", 8'h1C, {30'd0, p[1:0]});
            wr(8'h1C, 0);
            wr(8'h00, p ^ 32'h5A5A_0F0F);
            wr(8'h40, p + 7);      rd_chk("R14 spare", 8'h40, p + 7);
            rd_chk("R14 count untouched by spare", 8'h00, p ^ 32'h5A5A_0F0F);
        end
        rd_chk("R7 unused status bits", 8'h08, 0);

        // R3 / R4 / R8 / R13: tick period sweep
        for (int d = 0; d < 6; d++) begin
            wr(8'h1C, 0);
            wr(8'h0C, d);
            wr(8'h08, 32'h1B);     // clear pendings, enable tick
            wr(8'h00, 0);
            wr(8'h1C, 3);
            n = 0;
            while (n < 100) begin
                @(posedge clk); n++;
                @(negedge clk);
                if (irq) break;
            end
            chk("R3 tick period", n, 2 * (d + 1));
            wr(8'h1C, 0);
            rd_chk("R4 one step", 8'h00, 1);
            rd_chk("R8 tick pending", 8'h08, 32'h0A);
        end

        // R5 / R6: run then stop with various run-select values
        wr(8'h08, 32'h13);
        for (int d = 0; d < 4; d++) begin
            for (int k = 0; k < 3; k++) begin
                int m;
                logic [31:0] x;
                m = 1 + 4 * k + d;
                x = 32'h1000_0000 + d * 100 + m;
                wr(8'h1C, 0);
                wr(8'h0C, d);
                wr(8'h00, x);
                wr(8'h1C, 3);
                repeat (m) @(negedge clk);
                wr(8'h1C, k);      // 0, 1, 2: all stop
                rd_chk("R5 count after run", 8'h00, x + (m + 1) / (2 * (d + 1)));
                repeat (12) @(negedge clk);
                rd_chk("R6 frozen", 8'h00, x + (m + 1) / (2 * (d + 1)));
            end
        end

        // R4: wrap
        wr(8'h0C, 0);
        wr(8'h00, 32'hFFFF_FFFE);
        wr(8'h1C, 3);
        repeat (3) @(negedge clk);
        wr(8'h1C, 0);
        rd_chk("R4 wrap", 8'h00, 0);

        // R9 / R13: alarm A match, irq timing
        wr(8'h04, 32'h50);
        wr(8'h18, 32'h7777);
        wr(8'h00, 32'h4D);
        wr(8'h08, 32'h17);
        wr(8'h1C, 3);
        repeat (5) @(negedge clk);
        chk("R13 irq before match", {31'd0, irq}, 0);
        @(negedge clk);
        chk("R9 irq on match", {31'd0, irq}, 1);
        wr(8'h1C, 0);
        rd_chk("R7 status after alarm A", 8'h08, 32'h07);

        // R11: write-one-to-clear
        wr(8'h08, 32'h04);
        rd_chk("R11 zero leaves pending", 8'h08, 32'h07);
        wr(8'h08, 32'h05);
        rd_chk("R11 clear alarm A", 8'h08, 32'h06);
        chk("R13 irq low after clear", {31'd0, irq}, 0);
        wr(8'h08, 32'h02);
        rd_chk("R11 clear tick, drop enables", 8'h08, 0);

        // R9: disarmed alarm passes without setting
        wr(8'h00, 32'h4D);
        wr(8'h08, 32'h13);
        wr(8'h1C, 3);
        repeat (10) @(negedge clk);
        wr(8'h1C, 0);
        rd_chk("R9 disarmed", 8'h08, 32'h02);
        chk("R13 disabled tick no irq", {31'd0, irq}, 0);
        wr(8'h08, 32'h17);
        wr(8'h00, 32'h50);
        rd_chk("R9 load equal no set", 8'h08, 32'h04);

        // R10: alarm B across the wrap
        wr(8'h18, 0);
        wr(8'h00, 32'hFFFF_FFFD);
        wr(8'h08, 32'h53);
        wr(8'h1C, 3);
        repeat (5) @(negedge clk);
        chk("R10 irq before match", {31'd0, irq}, 0);
        @(negedge clk);
        chk("R10 irq on match", {31'd0, irq}, 1);
        wr(8'h1C, 0);
        rd_chk("R10 status", 8'h08, 32'h52);

        // R12: set and clear on the same edge (alarm A)
        wr(8'h00, 32'h4D);
        wr(8'h08, 32'h17);
        wr(8'h1C, 3);
        repeat (5) @(negedge clk);
        wr(8'h08, 32'h05);         // lands on the match edge
        wr(8'h1C, 0);
        rd_chk("R12 alarm set beats clear", 8'h08, 32'h07);

        // R12: set and clear on the same edge (tick)
        wr(8'h08, 32'h1B);
        wr(8'h00, 32'h0);
        wr(8'h1C, 3);
        @(negedge clk);
        wr(8'h08, 32'h0A);         // lands on the tick edge
        wr(8'h1C, 0);
        rd_chk("R12 tick set beats clear", 8'h08, 32'h0A);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule